// File: doc/BRIEF.md
# Pipeline Stall and Bubble Controller

This block decides, each cycle, whether the instruction sitting in the decode stage of a five-stage in-order pipeline may move on to execute. It compares the register numbers that the decode-stage instruction reads with the destination registers of the older instructions still in execute, memory access and write-back. When the value the instruction needs cannot reach it in time, the block raises a stall.

A stall freezes the program counter and the fetch/decode register, so both the fetched and the decoded instruction are held. It also turns the slot entering execute into a bubble with its memory-write and register-write enables cleared. The block is purely combinational, so the stall appears in the same cycle the hazard reaches decode.

A parameter selects the stall policy. With `FORWARD = 0` there are no bypass paths, and any pending write to a register that is read causes a stall. With `FORWARD = 1` bypass paths exist, and only a load in execute whose result is read by the very next instruction causes a stall, because the loaded value first becomes available for forwarding from the memory/write-back register.

Top module: `hazard_stall_ctrl`

## Requirements
- R1: With `FORWARD = 0`, a stall is raised whenever a source operand that is used and nonzero equals the destination of an execute, memory or write-back stage instruction whose register write-enable is 1.
- R2: With `FORWARD = 1`, a stall is raised only when the execute-stage instruction has its load flag (`ex_mem_rd`) at 1, its register write-enable at 1, and a destination equal to a used, nonzero source of the decode-stage instruction. Memory and write-back stages never cause a stall in this mode.
- R3: Register number 0 never creates a dependency, whether it appears as a source or as a destination.
- R4: A stage whose register write-enable is 0 never causes a stall, even when its destination matches.
- R5: A source operand whose use flag (`id_use_a` or `id_use_b`) is 0 is ignored for matching.
- R6: `pc_hold`, `ifid_hold` and `idex_bubble` are asserted together, combinationally, in the same cycle the hazard is present at the inputs.
- R7: While `idex_bubble` is 1, `ex_mem_we_nxt` and `ex_reg_we_nxt` are 0. Otherwise they equal `id_mem_we` and `id_reg_we`.
- R8: In a pipeline driven by these outputs, an instruction that reads the result of the instruction immediately ahead of it stalls 3 cycles without forwarding. A load followed at once by a dependent instruction stalls exactly 1 cycle with forwarding. Each independent instruction placed between the producer and the consumer removes one of these stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | First source register of the decode-stage instruction |
| id_src_b | input | REG_AW | Second source register of the decode-stage instruction |
| id_use_a | input | 1 | Decode-stage instruction reads its first source |
| id_use_b | input | 1 | Decode-stage instruction reads its second source |
| id_mem_we | input | 1 | Memory-write enable of the decode-stage instruction |
| id_reg_we | input | 1 | Register-write enable of the decode-stage instruction |
| ex_dst | input | REG_AW | Destination register held in the decode/execute register |
| ex_wen | input | 1 | Register write-enable held in the decode/execute register |
| ex_mem_rd | input | 1 | The execute-stage instruction is a load |
| mem_dst | input | REG_AW | Destination register held in the execute/memory register |
| mem_wen | input | 1 | Register write-enable held in the execute/memory register |
| wb_dst | input | REG_AW | Destination register held in the memory/write-back register |
| wb_wen | input | 1 | Register write-enable held in the memory/write-back register |
| pc_hold | output | 1 | Keep the program counter unchanged this cycle |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged this cycle |
| idex_bubble | output | 1 | Load a bubble into the decode/execute register |
| ex_mem_we_nxt | output | 1 | Memory-write enable to load into the decode/execute register |
| ex_reg_we_nxt | output | 1 | Register-write enable to load into the decode/execute register |

## Verification
The bench runs short instruction sequences through a behavioural pipeline model in both modes and counts stall cycles.

The sequences cover the following cases:
- **Adjacent ALU dependency.** A design that dropped the write-back comparison would give 2 stalls instead of 3.
- **Load followed by its consumer.** A controller that forgot the load flag would either stall on plain ALU results when forwarding, or never stall on loads.
- **Writes to register 0, and instructions with write-enable 0.** A design that compared register numbers blindly would stall on these.
- **An unused second operand that happens to match.** This catches a design that ignores the use flags.
- **Spacer instructions between producer and consumer.** These show whether the stall window shrinks by one per gap.

Every cycle, the write enables passed into execute are compared against the model. This catches a bubble that still writes.

// File: rtl/hazard_stall_ctrl.sv
module hazard_stall_ctrl #(
  parameter int REG_AW  = 5,
  parameter bit FORWARD = 1'b0
) (
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_use_a,
  input  logic              id_use_b,
  input  logic              id_mem_we,
  input  logic              id_reg_we,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wen,
  input  logic              ex_mem_rd,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wen,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wen,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble,
  output logic              ex_mem_we_nxt,
  output logic              ex_reg_we_nxt
);

  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  function automatic logic src_hit(input logic [REG_AW-1:0] dst, input logic wen,
                                   input logic [REG_AW-1:0] src, input logic used);
    return used && wen && (dst != ZERO_REG) && (src == dst);
  endfunction

  logic ex_hit, mem_hit, wb_hit, stall;

  assign ex_hit  = src_hit(ex_dst,  ex_wen,  id_src_a, id_use_a) | src_hit(ex_dst,  ex_wen,  id_src_b, id_use_b);
  assign mem_hit = src_hit(mem_dst, mem_wen, id_src_a, id_use_a) | src_hit(mem_dst, mem_wen, id_src_b, id_use_b);
  assign wb_hit  = src_hit(wb_dst,  wb_wen,  id_src_a, id_use_a) | src_hit(wb_dst,  wb_wen,  id_src_b, id_use_b);

  generate
    if (FORWARD) begin : g_load_use
      assign stall = ex_mem_rd & ex_hit;
    end else begin : g_full_dep
      assign stall = ex_hit | mem_hit | wb_hit;
    end
  endgenerate

  assign pc_hold       = stall;
  assign ifid_hold     = stall;
  assign idex_bubble   = stall;
  assign ex_mem_we_nxt = id_mem_we & ~stall;
  assign ex_reg_we_nxt = id_reg_we & ~stall;

  always_comb begin
    if (!((id_use_a && id_src_a != ZERO_REG) || (id_use_b && id_src_b != ZERO_REG)))
      p_zero_src_r3: assert (!pc_hold);
    if (!id_use_a && !id_use_b)
      p_unused_src_r5: assert (!ifid_hold);
    if (idex_bubble)
      p_bubble_kill_r7: assert (!ex_mem_we_nxt && !ex_reg_we_nxt);
    if (FORWARD) begin
      if (!ex_mem_rd || !ex_wen)
        p_fwd_load_only_r2: assert (!idex_bubble);
    end else begin
      if (!ex_wen && !mem_wen && !wb_wen)
        p_no_writer_r4: assert (!pc_hold);
      if (id_use_a && id_src_a != ZERO_REG && ex_wen && ex_dst == id_src_a)
        p_nofwd_ex_match_r1: assert (pc_hold);
    end
  end

endmodule

// File: tb/hazard_stall_ctrl_bench.sv
module hazard_stall_ctrl_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] src_a, src_b, ex_dst, mem_dst, wb_dst;
  logic use_a, use_b, id_mwe, id_rwe, ex_wen, ex_rd, mem_wen, wb_wen;
  logic nf_pc, nf_ifid, nf_bub, nf_mwe, nf_rwe;
  logic f_pc, f_ifid, f_bub, f_mwe, f_rwe;

  hazard_stall_ctrl #(.REG_AW(AW), .FORWARD(1'b0)) u_hazard_stall_ctrl (
    .id_src_a(src_a), .id_src_b(src_b), .id_use_a(use_a), .id_use_b(use_b),
    .id_mem_we(id_mwe), .id_reg_we(id_rwe), .ex_dst(ex_dst), .ex_wen(ex_wen),
    .ex_mem_rd(ex_rd), .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst),
    .wb_wen(wb_wen), .pc_hold(nf_pc), .ifid_hold(nf_ifid), .idex_bubble(nf_bub),
    .ex_mem_we_nxt(nf_mwe), .ex_reg_we_nxt(nf_rwe));

  hazard_stall_ctrl #(.REG_AW(AW), .FORWARD(1'b1)) u_hazard_stall_ctrl_fwd (
    .id_src_a(src_a), .id_src_b(src_b), .id_use_a(use_a), .id_use_b(use_b),
    .id_mem_we(id_mwe), .id_reg_we(id_rwe), .ex_dst(ex_dst), .ex_wen(ex_wen),
    .ex_mem_rd(ex_rd), .mem_dst(mem_dst), .mem_wen(mem_wen), .wb_dst(wb_dst),
    .wb_wen(wb_wen), .pc_hold(f_pc), .ifid_hold(f_ifid), .idex_bubble(f_bub),
    .ex_mem_we_nxt(f_mwe), .ex_reg_we_nxt(f_rwe));

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int p_dst[16], p_a[16], p_b[16];
  bit p_ua[16], p_ub[16], p_wen[16], p_rd[16], p_mw[16];
  int n_instr;
  int pc, s_id, s_ex, s_mem, s_wb;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_prog();
    n_instr = 0;
  endtask

  task automatic add(input int d, input int a, input int b, input bit ua, input bit ub,
                     input bit wen, input bit rd, input bit mw);
    p_dst[n_instr] = d; p_a[n_instr] = a; p_b[n_instr] = b;
    p_ua[n_instr] = ua; p_ub[n_instr] = ub; p_wen[n_instr] = wen;
    p_rd[n_instr] = rd; p_mw[n_instr] = mw;
    n_instr++;
  endtask

  function automatic bit model_stall(input bit fwd);
    int st[3];
    st[0] = s_ex; st[1] = s_mem; st[2] = s_wb;
    if (s_id < 0) return 1'b0;
    for (int k = 0; k < 3; k++) begin
      int w;
      w = st[k];
      if (w < 0) continue;
      if (fwd && (k != 0 || !p_rd[w])) continue;
      if (!p_wen[w] || p_dst[w] == 0) continue;
      if (p_ua[s_id] && p_a[s_id] == p_dst[w]) return 1'b1;
      if (p_ub[s_id] && p_b[s_id] == p_dst[w]) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic drive_stage_inputs();
    src_a  = (s_id  >= 0) ? AW'(p_a[s_id]) : '0;
    src_b  = (s_id  >= 0) ? AW'(p_b[s_id]) : '0;
    use_a  = (s_id  >= 0) ? p_ua[s_id] : 1'b0;
    use_b  = (s_id  >= 0) ? p_ub[s_id] : 1'b0;
    id_mwe = (s_id  >= 0) ? p_mw[s_id] : 1'b0;
    id_rwe = (s_id  >= 0) ? p_wen[s_id] : 1'b0;
    ex_dst = (s_ex  >= 0) ? AW'(p_dst[s_ex]) : '0;
    ex_wen = (s_ex  >= 0) ? p_wen[s_ex] : 1'b0;
    ex_rd  = (s_ex  >= 0) ? p_rd[s_ex] : 1'b0;
    mem_dst = (s_mem >= 0) ? AW'(p_dst[s_mem]) : '0;
    mem_wen = (s_mem >= 0) ? p_wen[s_mem] : 1'b0;
    wb_dst = (s_wb  >= 0) ? AW'(p_dst[s_wb]) : '0;
    wb_wen = (s_wb  >= 0) ? p_wen[s_wb] : 1'b0;
  endtask

  task automatic run_prog(input string req, input bit fwd, input int exp_stalls);
    int stalls;
    bit e_nf, e_f, st;
    stalls = 0;
    pc = 0; s_id = -1; s_ex = -1; s_mem = -1; s_wb = -1;
    for (int guard = 0; guard < 64; guard++) begin
      if (pc >= n_instr && s_id < 0 && s_ex < 0 && s_mem < 0 && s_wb < 0) break;
      @(posedge clk);
      #1;
      drive_stage_inputs();
      #3;
      e_nf = model_stall(1'b0);
      e_f  = model_stall(1'b1);
      chk("R1 no-forward stall", int'(nf_bub), int'(e_nf));
      chk("R2 forward stall", int'(f_bub), int'(e_f));
      chk("R6 pc hold agrees", int'(nf_pc) + 2 * int'(f_pc), int'(e_nf) + 2 * int'(e_f));
      chk("R6 ifid hold agrees", int'(nf_ifid) + 2 * int'(f_ifid), int'(e_nf) + 2 * int'(e_f));
      chk("R7 no-forward write enables",
          int'({nf_mwe, nf_rwe}), e_nf ? 0 : int'({id_mwe, id_rwe}));
      chk("R7 forward write enables",
          int'({f_mwe, f_rwe}), e_f ? 0 : int'({id_mwe, id_rwe}));
      st = fwd ? e_f : e_nf;
      if (st) stalls++;
      s_wb = s_mem;
      s_mem = s_ex;
      if (st) begin
        s_ex = -1;
      end else begin
        s_ex = s_id;
        s_id = (pc < n_instr) ? pc : -1;
        if (pc < n_instr) pc++;
      end
    end
    chk(req, stalls, exp_stalls);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    n_instr = 0;
    pc = 0; s_id = -1; s_ex = -1; s_mem = -1; s_wb = -1;
    drive_stage_inputs();
    repeat (3) @(posedge clk);
    #4;
    chk("R6 reset state no-forward hold", int'({nf_pc, nf_ifid, nf_bub}), 0);
    chk("R6 reset state forward hold", int'({f_pc, f_ifid, f_bub}), 0);
    rst_n = 1'b1;

    // R8 adjacent ALU dependency: add r3 ; sub r5,r3,r5
    clear_prog();
    add(3, 1, 2, 1, 1, 1, 0, 0);
    add(5, 3, 5, 1, 1, 1, 0, 0);
    run_prog("R8 alu dep no-forward 3 stalls", 1'b0, 3);
    run_prog("R8 alu dep forward 0 stalls", 1'b1, 0);

    // R8 load-use: lw r4 ; sub r6,r4,r1
    clear_prog();
    add(4, 8, 0, 1, 0, 1, 1, 0);
    add(6, 4, 1, 1, 1, 1, 0, 0);
    run_prog("R8 load-use forward 1 stall", 1'b1, 1);
    run_prog("R8 load-use no-forward 3 stalls", 1'b0, 3);

    // R8 load-use on operand B only, consumer is a store
    clear_prog();
    add(9, 2, 0, 1, 0, 1, 1, 0);
    add(0, 7, 9, 1, 1, 0, 0, 1);
    run_prog("R8 load-use src b forward 1 stall", 1'b1, 1);

    // R8 one gap between producer and consumer
    clear_prog();
    add(3, 1, 2, 1, 1, 1, 0, 0);
    add(7, 1, 1, 1, 1, 1, 0, 0);
    add(5, 3, 4, 1, 1, 1, 0, 0);
    run_prog("R8 one gap no-forward 2 stalls", 1'b0, 2);
    clear_prog();
    add(4, 8, 0, 1, 0, 1, 1, 0);
    add(7, 1, 1, 1, 1, 1, 0, 0);
    add(6, 4, 1, 1, 1, 1, 0, 0);
    run_prog("R8 load one gap forward 0 stalls", 1'b1, 0);

    // R3 register 0 as destination and source
    clear_prog();
    add(0, 1, 2, 1, 1, 1, 1, 0);
    add(5, 0, 0, 1, 1, 1, 0, 0);
    run_prog("R3 register 0 no-forward 0 stalls", 1'b0, 0);
    run_prog("R3 register 0 forward 0 stalls", 1'b1, 0);

    // R4 matching destination with write-enable 0
    clear_prog();
    add(3, 1, 2, 1, 1, 0, 1, 1);
    add(5, 3, 3, 1, 1, 1, 0, 0);
    run_prog("R4 write-enable 0 no-forward 0 stalls", 1'b0, 0);
    run_prog("R4 write-enable 0 forward 0 stalls", 1'b1, 0);

    // R5 unused operand B matches a pending write
    clear_prog();
    add(3, 1, 2, 1, 1, 1, 1, 0);
    add(5, 1, 3, 1, 0, 1, 0, 0);
    run_prog("R5 unused src b no-forward 0 stalls", 1'b0, 0);
    run_prog("R5 unused src b forward 0 stalls", 1'b1, 0);

    // R1 dependency two ahead plus one ahead, mixed chain
    clear_prog();
    add(3, 1, 2, 1, 1, 1, 0, 0);
    add(4, 3, 0, 1, 0, 1, 0, 0);
    add(6, 4, 3, 1, 1, 1, 0, 0);
    run_prog("R1 chained deps no-forward 6 stalls", 1'b0, 6);
    run_prog("R2 chained alu deps forward 0 stalls", 1'b1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule